// File: doc/BRIEF.md
# Data-Rate Prescaler with Scaled Protocol Timeouts

This block turns a fast core clock into a one-cycle bit-rate enable strobe, using a programmable power-of-two prescaler with five divide settings from 8 up to 128. The same setting, together with a flag that says whether the core clock is the doubled 40 MHz source or the plain 20 MHz one, sets a timeout multiplier. The multiplier is published on `tmo_scale`, so that every protocol timer in the controller stretches by the same amount as the bit period. With the doubled source and a divide of 8 the multiplier is 1, which is the 5 Mbps reference. Every halving of the bit rate doubles it, up to 32 at 156.25 Kbps.

The block also holds the idle-line timer. This timer counts bit strobes while the line is quiet. Because it counts in bit periods, its real-time length follows the data rate. With the default of 205 bit times it lasts 41 µs at 5 Mbps and about 1.3 ms at 156.25 Kbps. A new prescaler setting is taken only when the divider wraps, so no bit period is ever cut short.

Top module: `rate_timebase`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `bit_stb` and `idle_exp` are 0 and `tmo_scale` equals the multiplier of R5 computed from the `rate_sel` and `src_fast` values present during reset.
- R2: For `rate_sel` code k in 0..4, `bit_stb` is a single-cycle pulse that repeats every 2^(3+k) core cycles. The first pulse after reset comes 2^(3+k) cycles after reset is released.
- R3: `rate_sel` codes 5, 6 and 7 behave exactly as code 4, which is divide by 128.
- R4: A new `rate_sel` value is sampled only on the cycle in which `bit_stb` is raised. The period then in progress keeps its old length, and the next period uses the new one.
- R5: `tmo_scale` is a one-hot value equal to 2^(k + s), where k is the clamped select code and s is 0 when `src_fast` is 1 and 1 when it is 0. This gives values from 1 up to 32. It changes only in the cycle after a `bit_stb` cycle, and then takes the value sampled at that wrap.
- R6: A change on `src_fast` is adopted at the same divider wrap as the select code, and has no effect on the strobe period.
- R7: When `line_active` stays 0, `idle_exp` rises for exactly one cycle, one cycle after the IDLE_BITS-th `bit_stb` pulse counted since reset or since the last activity.
- R8: Any cycle with `line_active` at 1 clears the idle count, and `idle_exp` is 0 in the following cycle.
- R9: While the line stays quiet, `idle_exp` repeats every IDLE_BITS bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| src_fast | input | 1 | 1: core clock is the doubled 40 MHz source; 0: 20 MHz |
| rate_sel | input | SEL_W | Prescaler code, divide = 2^(3+code), codes above 4 clamp to 4 |
| line_active | input | 1 | High in any cycle the receiver sees line activity |
| bit_stb | output | 1 | One-cycle bit-rate enable |
| tmo_scale | output | NUM_RATES+1 | One-hot timeout multiplier |
| idle_exp | output | 1 | One-cycle idle-line timeout pulse |

## Verification
The bench sweeps every select code under both clock-source flags. It compares each strobe position against an arithmetic period model, so a wrong divide table or a missing clamp for codes 5 to 7 shows up as a strobe in the wrong cycle. Selects and the source flag are then changed at odd offsets inside a period. A design that adopts a new setting at once, instead of at the wrap, produces a short or long period, or moves `tmo_scale` early. Random bursts of line activity, mixed with long quiet stretches, target the idle timer. A timer that does not restart on activity, that fires one bit early or late, or that fails to re-arm after expiry gives `idle_exp` in the wrong cycle.

// File: rtl/rate_timebase_pkg.sv
package rate_timebase_pkg;

  // Limit a select code to the highest implemented rate index.
  function automatic int clamp_sel(input int code, input int num_rates);
    return (code > num_rates - 1) ? num_rates - 1 : code;
  endfunction

  // Timeout multiplier relative to the fastest rate: one extra doubling
  // when the core runs from the undoubled source.
  function automatic int rate_factor(input int idx, input bit fast_src);
    return 1 << (idx + (fast_src ? 0 : 1));
  endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import rate_timebase_pkg::*;
#(
  parameter int DIV_LOG_MIN = 3,
  parameter int NUM_RATES   = 5,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_fast,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             bit_stb,
  output logic [SEL_W-1:0] sel_act,
  output logic             fast_act
);
  localparam int CNT_W = DIV_LOG_MIN + NUM_RATES - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_tab [NUM_RATES];
  logic [SEL_W-1:0] sel_clamped;
  logic             wrap;

  // Terminal count for each rate, one entry per divide setting.
  generate
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
      assign lim_tab[g] = CNT_W'((1 << (DIV_LOG_MIN + g)) - 1);
    end
  endgenerate

  assign sel_clamped = SEL_W'(clamp_sel(int'(rate_sel), NUM_RATES));
  assign wrap        = (cnt == lim_tab[sel_act]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      bit_stb  <= 1'b0;
      sel_act  <= sel_clamped;
      fast_act <= src_fast;
    end else if (wrap) begin
      cnt      <= '0;
      bit_stb  <= 1'b1;
      sel_act  <= sel_clamped;
      fast_act <= src_fast;
    end else begin
      cnt      <= cnt + 1'b1;
      bit_stb  <= 1'b0;
    end
  end
endmodule

// File: rtl/scale_gen.sv
module scale_gen
  import rate_timebase_pkg::*;
#(
  parameter int NUM_RATES = 5,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     rate_sel,
  input  logic                 src_fast,
  input  logic [SEL_W-1:0]     sel_act,
  input  logic                 fast_act,
  output logic [NUM_RATES:0]   tmo_scale
);
  localparam int SCALE_W = NUM_RATES + 1;

  logic [SCALE_W-1:0] fac_rst;
  logic [SCALE_W-1:0] fac_run;

  assign fac_rst = SCALE_W'(rate_factor(clamp_sel(int'(rate_sel), NUM_RATES), src_fast));
  assign fac_run = SCALE_W'(rate_factor(int'(sel_act), fast_act));

  always_ff @(posedge clk) begin
    if (rst) tmo_scale <= fac_rst;
    else     tmo_scale <= fac_run;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int IDLE_BITS = 205
) (
  input  logic clk,
  input  logic rst,
  input  logic line_active,
  input  logic bit_stb,
  output logic idle_exp
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] bits_quiet;

  always_ff @(posedge clk) begin
    if (rst || line_active) begin
      bits_quiet <= '0;
      idle_exp   <= 1'b0;
    end else if (bit_stb) begin
      if (bits_quiet == LAST) begin
        bits_quiet <= '0;
        idle_exp   <= 1'b1;
      end else begin
        bits_quiet <= bits_quiet + 1'b1;
        idle_exp   <= 1'b0;
      end
    end else begin
      idle_exp <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_timebase.sv
module rate_timebase #(
  parameter int DIV_LOG_MIN = 3,
  parameter int NUM_RATES   = 5,
  parameter int SEL_W       = 3,
  parameter int IDLE_BITS   = 205
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_fast,
  input  logic [SEL_W-1:0]   rate_sel,
  input  logic               line_active,
  output logic               bit_stb,
  output logic [NUM_RATES:0] tmo_scale,
  output logic               idle_exp
);
  logic [SEL_W-1:0] sel_act;
  logic             fast_act;

  rate_divider #(
    .DIV_LOG_MIN(DIV_LOG_MIN),
    .NUM_RATES  (NUM_RATES),
    .SEL_W      (SEL_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .src_fast(src_fast),
    .rate_sel(rate_sel),
    .bit_stb (bit_stb),
    .sel_act (sel_act),
    .fast_act(fast_act)
  );

  scale_gen #(
    .NUM_RATES(NUM_RATES),
    .SEL_W    (SEL_W)
  ) u_scale (
    .clk      (clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .src_fast (src_fast),
    .sel_act  (sel_act),
    .fast_act (fast_act),
    .tmo_scale(tmo_scale)
  );

  idle_timer #(
    .IDLE_BITS(IDLE_BITS)
  ) u_idle (
    .clk        (clk),
    .rst        (rst),
    .line_active(line_active),
    .bit_stb    (bit_stb),
    .idle_exp   (idle_exp)
  );
endmodule

// File: rtl/rate_timebase_chk.sv
module rate_timebase_chk #(
  parameter int NUM_RATES   = 5,
  parameter int DIV_LOG_MIN = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               line_active,
  input logic               bit_stb,
  input logic [NUM_RATES:0] tmo_scale,
  input logic               idle_exp
);
  localparam int MIN_GAP = (1 << DIV_LOG_MIN) - 1;

  // Cycles since the last strobe, saturating; starts long at reset.
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    if (rst)             gap <= 8'(MIN_GAP);
    else if (bit_stb)    gap <= '0;
    else if (gap != 8'hFF) gap <= gap + 1'b1;
  end

  assert_single_stb_R2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  assert_no_short_period_R4: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> (gap >= 8'(MIN_GAP)));

  assert_scale_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(tmo_scale) == 1);

  assert_scale_moves_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_stb) && !$past(rst)) |-> $stable(tmo_scale));

  assert_idle_follows_stb_R7: assert property (@(posedge clk) disable iff (rst)
    idle_exp |-> $past(bit_stb));

  assert_idle_single_R7: assert property (@(posedge clk) disable iff (rst)
    idle_exp |=> !idle_exp);

  assert_activity_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    line_active |=> !idle_exp);
endmodule

bind rate_timebase rate_timebase_chk #(
  .NUM_RATES  (NUM_RATES),
  .DIV_LOG_MIN(DIV_LOG_MIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_active(line_active),
  .bit_stb    (bit_stb),
  .tmo_scale  (tmo_scale),
  .idle_exp   (idle_exp)
);

// File: tb/sim_rate_timebase.sv
`timescale 1ns/1ps
module sim_rate_timebase;
  localparam int NB = 6;   // short idle window for the sweeps

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_fast = 1'b1;
  logic [2:0] rate_sel = 3'd0;
  logic       line_active = 1'b0;
  logic       bit_stb;
  logic [5:0] tmo_scale;
  logic       idle_exp;

  always #2 clk = ~clk;

  rate_timebase #(.IDLE_BITS(NB)) u0 (
    .clk(clk), .rst(rst), .src_fast(src_fast), .rate_sel(rate_sel),
    .line_active(line_active), .bit_stb(bit_stb), .tmo_scale(tmo_scale),
    .idle_exp(idle_exp)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Reference model state
  int cd;
  int mc;
  bit exp_stb, exp_idle, pend;
  int exp_scale, pend_val;
  string tag_s, tag_c, tag_i;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int clampk(int s);
    return (s > 4) ? 4 : s;
  endfunction
  function automatic int divof(int s);
    return 1 << (3 + clampk(s));
  endfunction
  function automatic int facof(int s, bit f);
    return 1 << (clampk(s) + (f ? 0 : 1));
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int s, input bit f);
    rst = 1'b1; rate_sel = 3'(s); src_fast = f; line_active = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    chk("R1", int'(bit_stb), 0, "bit_stb in reset");
    chk("R1", int'(idle_exp), 0, "idle_exp in reset");
    chk("R1", int'(tmo_scale), facof(s, f), "tmo_scale in reset");
    cd = divof(s); mc = 0; exp_stb = 0; exp_idle = 0; pend = 0;
    exp_scale = facof(s, f);
    rst = 1'b0;
  endtask

  task automatic step();
    bit prev;
    @(posedge clk);
    prev = exp_stb;
    // idle model
    if (line_active) begin mc = 0; exp_idle = 0; end
    else if (prev) begin
      if (mc == NB - 1) begin exp_idle = 1; mc = 0; end
      else begin mc++; exp_idle = 0; end
    end else exp_idle = 0;
    // scale model: new value one cycle after the wrap
    if (pend) begin exp_scale = pend_val; pend = 0; end
    // divider model
    cd--;
    if (cd == 0) begin
      exp_stb = 1; cd = divof(int'(rate_sel));
      pend = 1; pend_val = facof(int'(rate_sel), src_fast);
    end else exp_stb = 0;
    @(negedge clk);
    chk(tag_s, int'(bit_stb), int'(exp_stb), "bit_stb");
    chk(tag_c, int'(tmo_scale), exp_scale, "tmo_scale");
    chk(tag_i, int'(idle_exp), int'(exp_idle), "idle_exp");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 with a fast setting, then the first strobe position (R2)
    do_reset(0, 1'b1);
    tag_s = "R2"; tag_c = "R1"; tag_i = "R7";
    step();   // first cycle after release still reset-like (R1)
    tag_c = "R5";
    repeat (60) step();

    // Sweep every code under both sources; quiet line so idle repeats (R9)
    for (int f = 1; f >= 0; f--) begin
      for (int s = 0; s < 8; s++) begin
        rate_sel = 3'(s); src_fast = f[0];
        tag_s = (s > 4) ? "R3" : "R2";
        tag_c = "R5"; tag_i = "R9";
        repeat (900) step();
      end
    end

    // R1/R3: reset with a clamped code on the slow source, expect 32
    do_reset(6, 1'b0);
    tag_s = "R3"; tag_c = "R1"; tag_i = "R7";
    step();
    tag_c = "R5";
    repeat (1200) step();

    // R4/R6: change select and source at odd offsets inside periods
    tag_s = "R4"; tag_c = "R6"; tag_i = "R7";
    for (int i = 0; i < 120; i++) begin
      rate_sel = 3'((i * 3) % 6);
      if (i % 5 == 0) src_fast = ~src_fast;
      repeat (37 + (i % 11)) step();
    end

    // R8: bursts of line activity, at two rates
    tag_s = "R2"; tag_c = "R5"; tag_i = "R8";
    for (int r = 0; r < 2; r++) begin
      rate_sel = 3'(r); src_fast = 1'b1;
      for (int i = 0; i < 6000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        line_active = (i % 700 < 350) ? (lfsr[3:0] == 4'd0) : 1'b0;
        step();
      end
    end
    line_active = 1'b0;
    tag_i = "R7";
    repeat (400) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule